// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit up-counting timer that turns two compare values into a square wave of chosen frequency and duty on one output. A period compare sets when the count wraps, and a duty compare sets where the wave changes level inside each period. The output flips on a match with either compare. Each compare also raises its own single-cycle interrupt strobe in the cycle of its match.

The duty compare can take software writes at once, or it can hold them in a buffer. In buffered mode, a new duty value moves into the active compare only on a period match, so the wave never shows a half-updated period. The idle level of the output sets the polarity: with idle level 0 the output starts low, and the pulse between the duty match and the period match is high. With idle level 1 the whole waveform is inverted. Clearing the run control stops the timer, clears the count and puts the output back to its idle level. The duty value must stay below the period value.

Top module: `ppg_timer`

## Requirements
- R1: While running, a count equal to the active duty compare inverts `pulse_out` on the next clock edge.
- R2: While running, a count equal to the period compare inverts `pulse_out` and sets the count to 0 on the next clock edge. One full period is therefore period value + 1 cycles. Otherwise the count rises by one each cycle.
- R3: `duty_irq` is high for exactly the cycles in which the timer runs and the count equals the active duty compare. It is combinational, in the same cycle as the match.
- R4: `period_irq` is high for exactly the cycles in which the timer runs and the count equals the period compare. It is combinational, in the same cycle as the match.
- R5: With `dbuf_en`=1, a duty write (`duty_wr`=1 with `wr_data`) goes only to the buffer. The active duty compare changes only on a clock edge that has a period match, and it then takes the buffer contents.
- R6: With `dbuf_en`=0, a duty write sets the active duty compare on that clock edge. A period write (`period_wr`=1) always takes effect on its clock edge.
- R7: With `dbuf_en`=1, a duty write in a period-match cycle loads the old buffer contents into the active compare, and the new value stays in the buffer until the next period match.
- R8: With `run_en`=0, both strobes are low, and on the next edge the count becomes 0 and `pulse_out` becomes `idle_level`.
- R9: After reset, `pulse_out`=0, the count is 0 and both compare values and the buffer are 0.
- R10: With `idle_level`=1, the waveform is the bitwise inverse of the one produced with `idle_level`=0 (active-low pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 counts, 0 stops and clears |
| duty_wr | input | 1 | Write strobe for the duty compare |
| period_wr | input | 1 | Write strobe for the period compare |
| wr_data | input | 16 | Write value for either compare |
| dbuf_en | input | 1 | 1 selects buffered duty writes |
| idle_level | input | 1 | Output level while stopped |
| pulse_out | output | 1 | Square wave output |
| duty_irq | output | 1 | Duty match strobe |
| period_irq | output | 1 | Period match strobe |

## Verification
A wrong count or a wrong compare value shows first on the strobes, in the same cycle as the missed or extra match. It then shows on `pulse_out` one edge later, and the error carries into every later period because the output is a running toggle. A buffer that loads at the wrong time moves the duty strobe by whole periods, so the bench compares every cycle against a reference model. It does not check only the edges. The collision case and stop/restart with both idle levels are driven on purpose, because those are the cases where a wrong priority shows.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // Next output level: hold idle when stopped, else flip once per match event
  function automatic logic wave_next(input logic cur, input logic run,
                                     input logic idle, input logic ev_a,
                                     input logic ev_b);
    if (!run) return idle;
    return cur ^ (ev_a ^ ev_b);
  endfunction

  // Whether a duty write lands directly in the active compare
  function automatic logic direct_load(input logic wr, input logic buffered);
    return wr && !buffered;
  endfunction
endpackage

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             wrap,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run_en || wrap) cnt <= '0;
    else                      cnt <= cnt + ONE;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !wrap) |=> cnt == $past(cnt) + ONE);
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wrap) |=> cnt == '0);
  // R8
  cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt == '0);
endmodule

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duty_wr,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dbuf_en,
  input  logic             wrap,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] period_val
);
  logic [CNT_W-1:0] duty_buf;
  logic             load_direct;
  logic             load_shift;

  assign load_direct = direct_load(duty_wr, dbuf_en);
  assign load_shift  = dbuf_en && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_buf   <= '0;
      duty_act   <= '0;
      period_val <= '0;
    end else begin
      if (duty_wr)          duty_buf <= wr_data;
      if (period_wr)        period_val <= wr_data;
      if (load_direct)      duty_act <= wr_data;
      else if (load_shift)  duty_act <= duty_buf;
    end
  end

  // R6
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_wr && !dbuf_en) |=> duty_act == $past(wr_data));
  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !wrap) |=> $stable(duty_act));
  // R7
  buf_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && wrap) |=> duty_act == $past(duty_buf));
endmodule

// File: rtl/ppg_wave.sv
module ppg_wave
  import ppg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic idle_level,
  input  logic duty_hit,
  input  logic period_hit,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= wave_next(pulse, run_en, idle_level, duty_hit, period_hit);
  end

  // R1
  duty_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && duty_hit && !period_hit) |=> pulse != $past(pulse));
  // R2
  period_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && period_hit && !duty_hit) |=> pulse != $past(pulse));
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> pulse == $past(idle_level));
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             duty_wr,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dbuf_en,
  input  logic             idle_level,
  output logic             pulse_out,
  output logic             duty_irq,
  output logic             period_irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] period_val;
  logic             duty_hit;
  logic             period_hit;

  assign duty_hit   = run_en && (cnt == duty_act);
  assign period_hit = run_en && (cnt == period_val);

  ppg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wrap(period_hit), .cnt(cnt)
  );

  ppg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr), .period_wr(period_wr),
    .wr_data(wr_data), .dbuf_en(dbuf_en), .wrap(period_hit),
    .duty_act(duty_act), .period_val(period_val)
  );

  ppg_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .idle_level(idle_level),
    .duty_hit(duty_hit), .period_hit(period_hit), .pulse(pulse_out)
  );

  assign duty_irq   = duty_hit;
  assign period_irq = period_hit;

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !duty_irq && !period_irq);
  // R4
  period_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_irq && period_val != '0) |=> !period_irq);
endmodule

// File: tb/ppg_timer_bench.sv
`timescale 1ns/1ps
module ppg_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, run_en, duty_wr, period_wr, dbuf_en, idle_level;
  logic [15:0] wr_data;
  logic        pulse_out, duty_irq, period_irq;

  always #5 clk = ~clk;

  ppg_timer u_ppg_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .duty_wr(duty_wr),
    .period_wr(period_wr), .wr_data(wr_data), .dbuf_en(dbuf_en),
    .idle_level(idle_level), .pulse_out(pulse_out), .duty_irq(duty_irq),
    .period_irq(period_irq)
  );

  typedef struct {
    logic  out;
    logic  dirq;
    logic  pirq;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_run = 0, n_fail = 0;
  string cur_tag = "R9";

  // reference model state
  logic [15:0] m_cnt = '0, m_duty = '0, m_buf = '0, m_per = '0;
  logic        m_out = 1'b0;

  // Driver: apply one cycle of inputs, push expected outputs, advance model
  task automatic step(input logic rst, input logic run, input logic dw,
                      input logic pw, input logic [15:0] d, input logic den,
                      input logic lvl);
    exp_t e;
    logic dh, ph;
    @(negedge clk);
    rst_n = rst; run_en = run; duty_wr = dw; period_wr = pw;
    wr_data = d; dbuf_en = den; idle_level = lvl;
    if (!rst) begin
      m_cnt = '0; m_duty = '0; m_buf = '0; m_per = '0; m_out = 1'b0;
      dh = 1'b0; ph = 1'b0;
    end else begin
      dh = run && (m_cnt == m_duty);
      ph = run && (m_cnt == m_per);
    end
    e.out = m_out; e.dirq = dh; e.pirq = ph; e.tag = cur_tag;
    sb_q.push_back(e);
    if (rst) begin
      if (!run)          m_out = lvl;
      else if (dh != ph) m_out = !m_out;
      m_cnt = (!run || ph) ? 16'd0 : m_cnt + 16'd1;
      if (dw && !den)    m_duty = d;
      else if (den && ph) m_duty = m_buf;
      if (dw) m_buf = d;
      if (pw) m_per = d;
    end
  endtask

  task automatic idle_run(input int n, input logic den, input logic lvl);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 16'd0, den, lvl);
  endtask

  // Monitor: pop and compare away from the clock edge
  always @(negedge clk) begin
    #3;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (pulse_out !== e.out || duty_irq !== e.dirq || period_irq !== e.pirq) begin
        n_fail++;
        $display("FAIL %s: out/dirq/pirq actual %b%b%b expected %b%b%b", e.tag,
                 pulse_out, duty_irq, period_irq, e.out, e.dirq, e.pirq);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; run_en = 0; duty_wr = 0; period_wr = 0; wr_data = '0;
    dbuf_en = 0; idle_level = 0;
    // R9 reset state
    cur_tag = "R9";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 16'd0, 0, 0);
    // program period 9, duty 3 while stopped
    cur_tag = "R6";
    step(1, 0, 0, 1, 16'd9, 0, 0);
    step(1, 0, 1, 0, 16'd3, 0, 0);
    // R1 R2 R3 R4 basic waveform, several periods
    cur_tag = "R1_R2_R3_R4";
    idle_run(35, 0, 0);
    // R6 direct duty change mid-period
    cur_tag = "R6";
    step(1, 1, 1, 0, 16'd6, 0, 0);
    idle_run(22, 0, 0);
    // R6 period change mid-run
    step(1, 1, 0, 1, 16'd12, 0, 0);
    idle_run(30, 0, 0);
    // R5 buffered write deferred to period match
    cur_tag = "R5";
    step(1, 1, 1, 0, 16'd2, 1, 0);
    idle_run(30, 1, 0);
    // R7 write in the period-match cycle
    cur_tag = "R7";
    step(1, 1, 1, 0, 16'd8, 1, 0);
    while (m_cnt != m_per) step(1, 1, 0, 0, 16'd0, 1, 0);
    step(1, 1, 1, 0, 16'd4, 1, 0);
    idle_run(30, 1, 0);
    // R8 stop with idle high, restart active-low
    cur_tag = "R8";
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 16'd0, 0, 1);
    cur_tag = "R10";
    idle_run(40, 0, 1);
    cur_tag = "R8";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 16'd0, 0, 0);
    cur_tag = "R1_R2";
    idle_run(20, 0, 0);
    step(1, 0, 0, 0, 16'd0, 0, 0);
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule